// File: doc/BRIEF.md
# Quadrature Knob Direction Decoder

This block turns the two phase signals of a rotary knob into a direction bit and a clock-like count signal. Both phases must already be free of contact bounce when they arrive. On every clock edge the block compares the current phase pair with the pair it held before. A single legal Gray-code step toggles the count output and sets the direction bit for that step. A pair that is unchanged, or that jumps two positions at once, leaves both outputs as they were.

The phase pair is read as the two-bit value {A,B}, with A as the upper bit. The clockwise walk is 00, 01, 11, 10 and then 00 again. Counter-clockwise is the same walk backwards. Every legal step toggles count, so the four steps of one detent give two full high/low cycles of count. Downstream logic can use count as a slow clock and sample the direction bit alongside it.

Top module: `knob_quad_decoder`

## Requirements
- R1: With {phase_a,phase_b} read as a 2-bit value (phase_a is the MSB), a step along 00→01→11→10→00 is clockwise: on the clock edge that samples it, dir_o becomes 0.
- R2: A step along the reverse walk 00→10→11→01→00 is counter-clockwise: on the clock edge that samples it, dir_o becomes 1.
- R3: Every legal step, in either direction, inverts count_o on the edge that samples it. The four steps of one detent therefore give two rising edges of count_o, and count_o ends at its starting level.
- R4: When the sampled pair equals the previous pair, count_o and dir_o keep their values. The direction bit holds while the knob is at rest.
- R5: When both phases change between two samples (an illegal jump), count_o and dir_o keep their values. The new pair becomes the reference for the next step.
- R6: A synchronous active-high reset drives count_o to 0 and dir_o to 0, and loads the pair present during reset as the reference.
- R7: Outputs react on the first rising clock edge at which a new pair is sampled, with no extra pipeline stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a | input | 1 | Debounced knob phase A (upper bit of the pair) |
| phase_b | input | 1 | Debounced knob phase B (lower bit of the pair) |
| count_o | output | 1 | Toggles once per legal step |
| dir_o | output | 1 | 0 = clockwise, 1 = counter-clockwise, held between steps |

## Verification
The bench steps through both rotation directions from every starting pair. A decoder with its step table mirrored would report the wrong direction bit, and one that counted edges of a single phase would toggle count at half the rate. The bench holds the knob at rest and checks that a design clearing the direction bit when idle is caught. It injects two-bit jumps to catch a design that toggles count on them or keeps the old reference afterwards. It also resets with non-zero phases to catch a design that loads a fixed reference, which would misread the first step.

// File: rtl/knob_quad_pkg.sv
package knob_quad_pkg;

    localparam int PAIR_W = 2;

    typedef logic [PAIR_W-1:0] pair_t;

    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_CW   = 2'd1,
        STEP_CCW  = 2'd2,
        STEP_JUMP = 2'd3
    } step_t;

    typedef struct packed {
        logic count;
        logic dir;
    } knob_out_t;

    // Gray pair to ring position 0..3
    function automatic logic [1:0] pair_to_pos(input pair_t p);
        return {p[1], p[1] ^ p[0]};
    endfunction

    // Ring position back to the Gray pair
    function automatic pair_t pos_to_pair(input logic [1:0] n);
        return {n[1], n[1] ^ n[0]};
    endfunction

    function automatic step_t classify(input pair_t prev, input pair_t cur);
        logic [1:0] pos;
        pos = pair_to_pos(prev);
        if (cur == prev)
            return STEP_IDLE;
        else if (cur == pos_to_pair(pos + 2'd1))
            return STEP_CW;
        else if (cur == pos_to_pair(pos - 2'd1))
            return STEP_CCW;
        else
            return STEP_JUMP;
    endfunction

endpackage

// File: rtl/knob_pair_reg.sv
module knob_pair_reg
    import knob_quad_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pair_t pair_in,
    output pair_t pair_ref
);
    // The reference follows every sample, reset included, so after a
    // jump the next step is judged from the newly seen pair.
    always_ff @(posedge clk) begin
        if (rst)
            pair_ref <= pair_in;
        else
            pair_ref <= pair_in;
    end
endmodule

// File: rtl/knob_step_detect.sv
module knob_step_detect
    import knob_quad_pkg::*;
(
    input  pair_t prev_pair,
    input  pair_t cur_pair,
    output step_t step
);
    always_comb begin
        step = classify(prev_pair, cur_pair);
    end
endmodule

// File: rtl/knob_out_gen.sv
module knob_out_gen
    import knob_quad_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  step_t     step,
    output knob_out_t state
);
    knob_out_t nxt;

    always_comb begin
        nxt = state;
        unique case (step)
            STEP_CW: begin
                nxt.count = ~state.count;
                nxt.dir   = 1'b0;
            end
            STEP_CCW: begin
                nxt.count = ~state.count;
                nxt.dir   = 1'b1;
            end
            STEP_IDLE, STEP_JUMP: nxt = state;
            default:              nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= '0;
        else
            state <= nxt;
    end
endmodule

// File: rtl/knob_quad_decoder.sv
module knob_quad_decoder
    import knob_quad_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic phase_a,
    input  logic phase_b,
    output logic count_o,
    output logic dir_o
);
    pair_t     cur_pair;
    pair_t     ref_pair;
    step_t     step;
    knob_out_t out_q;

    assign cur_pair = {phase_a, phase_b};

    knob_pair_reg u_ref (
        .clk      (clk),
        .rst      (rst),
        .pair_in  (cur_pair),
        .pair_ref (ref_pair)
    );

    knob_step_detect u_detect (
        .prev_pair (ref_pair),
        .cur_pair  (cur_pair),
        .step      (step)
    );

    knob_out_gen u_out (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .state (out_q)
    );

    assign count_o = out_q.count;
    assign dir_o   = out_q.dir;
endmodule

// File: rtl/knob_quad_decoder_chk.sv
module knob_quad_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       phase_a,
    input logic       phase_b,
    input logic       count_o,
    input logic       dir_o,
    input logic [1:0] ref_pair
);
    logic [1:0] cur;
    logic       is_cw;
    logic       is_ccw;
    logic       is_same;
    logic       is_jump;

    assign cur = {phase_a, phase_b};

    // Legal moves listed explicitly, separate from the design's ring arithmetic
    always_comb begin
        is_cw  = (ref_pair == 2'b00 && cur == 2'b01) || (ref_pair == 2'b01 && cur == 2'b11) ||
                 (ref_pair == 2'b11 && cur == 2'b10) || (ref_pair == 2'b10 && cur == 2'b00);
        is_ccw = (ref_pair == 2'b01 && cur == 2'b00) || (ref_pair == 2'b11 && cur == 2'b01) ||
                 (ref_pair == 2'b10 && cur == 2'b11) || (ref_pair == 2'b00 && cur == 2'b10);
        is_same = (ref_pair == cur);
        is_jump = (ref_pair ^ cur) == 2'b11;
    end

    // R1
    cw_step_chk: assert property (@(posedge clk) disable iff (rst)
        is_cw |=> (dir_o == 1'b0));

    // R2
    ccw_step_chk: assert property (@(posedge clk) disable iff (rst)
        is_ccw |=> (dir_o == 1'b1));

    // R3
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (is_cw || is_ccw) |=> (count_o != $past(count_o)));

    // R4
    rest_hold_chk: assert property (@(posedge clk) disable iff (rst)
        is_same |=> ($stable(count_o) && $stable(dir_o)));

    // R5
    jump_hold_chk: assert property (@(posedge clk) disable iff (rst)
        is_jump |=> ($stable(count_o) && $stable(dir_o)));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (count_o == 1'b0 && dir_o == 1'b0));
endmodule

bind knob_quad_decoder knob_quad_decoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .phase_a  (phase_a),
    .phase_b  (phase_b),
    .count_o  (count_o),
    .dir_o    (dir_o),
    .ref_pair (ref_pair)
);

// File: tb/knob_quad_decoder_tb.sv
module knob_quad_decoder_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase_a = 1'b0;
    logic phase_b = 1'b0;
    logic count_o;
    logic dir_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    knob_quad_decoder u_dut (
        .clk     (clk),
        .rst     (rst),
        .phase_a (phase_a),
        .phase_b (phase_b),
        .count_o (count_o),
        .dir_o   (dir_o)
    );

    // Each entry: {a, b, expected count, expected dir}, starting from reset with pair 00
    localparam int NV = 16;
    localparam logic [3:0] VEC [NV] = '{
        4'b01_1_0, 4'b11_0_0, 4'b10_1_0, 4'b00_0_0,
        4'b01_1_0, 4'b11_0_0, 4'b11_0_0, 4'b01_1_1,
        4'b00_0_1, 4'b10_1_1, 4'b11_0_1, 4'b11_0_1,
        4'b00_0_1, 4'b01_1_0, 4'b10_1_0, 4'b11_0_1
    };

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual count/dir=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive a pair at a falling edge; the outputs settle after the next rising edge
    task automatic apply(input logic [1:0] p);
        @(negedge clk);
        phase_a = p[1];
        phase_b = p[0];
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] p);
        @(negedge clk);
        rst = 1'b1;
        phase_a = p[1];
        phase_b = p[0];
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int rises;
        logic last_c;
        do_reset(2'b00);
        check("R6 reset state", {count_o, dir_o}, 2'b00);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][3:2]);
            check($sformatf("R1/R2/R3/R4/R5/R7 vector %0d", i),
                  {count_o, dir_o}, VEC[i][1:0]);
        end

        // R6: reset clears outputs that are high (the table leaves dir=1)
        do_reset(2'b11);
        check("R6 reset clears outputs", {count_o, dir_o}, 2'b00);
        // R6: reference loaded at 11, so 10 is clockwise
        apply(2'b10);
        check("R6 reference from reset pair (cw)", {count_o, dir_o}, 2'b10);

        do_reset(2'b11);
        apply(2'b01);
        check("R2 reference from reset pair (ccw)", {count_o, dir_o}, 2'b11);

        // R3: one full clockwise detent gives two rising edges and returns to its start level
        do_reset(2'b10);
        rises = 0;
        last_c = count_o;
        foreach (VEC[k]) begin
            if (k < 4) begin
                apply(k == 0 ? 2'b00 : k == 1 ? 2'b01 : k == 2 ? 2'b11 : 2'b10);
                if (count_o && !last_c) rises++;
                last_c = count_o;
            end
        end
        check("R3 two count cycles per detent", {1'b0, count_o}, 2'b00);
        check("R3 rising edge count", rises[1:0], 2'd2);
        check("R1 direction after cw detent", {1'b0, dir_o}, 2'b00);

        // R4: a long rest keeps the direction bit
        apply(2'b11);   // ccw from 10
        for (int j = 0; j < 20; j++) @(negedge clk);
        check("R4 direction held at rest", {count_o, dir_o}, 2'b11);

        // R5: jump 11 -> 00 ignored, then 00 -> 10 judged from the new reference (ccw)
        apply(2'b00);
        check("R5 jump ignored", {count_o, dir_o}, 2'b11);
        apply(2'b10);
        check("R5 reference updated after jump", {count_o, dir_o}, 2'b01);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule